// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources and drives two processor request lines. One is a normal interrupt request and the other is a fast interrupt request. Both lines are computed from one shared vector of source levels. Each line has its own enable mask, and the line is asserted when any enabled source is high. The enable bits are changed only through separate set and clear registers, so software can alter its own bits with a single write and leave the other bits alone.

Source 0 can also be raised from software. A dedicated set/clear pair holds a software level, and this level is ORed onto hardware source 0. Software can therefore generate an interrupt on either line without any external stimulus.

Access uses a word-indexed register port. Writes take effect on a clock edge. Reads are combinational from the current address and state. Both request lines come from registers, so each one changes exactly one clock after the level, enable or software bit that drives it.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: After synchronous reset both enable masks and the software level are zero and both request outputs are low.
- R2: Reading index 1 or index 9 returns the raw level vector: each bit equals its source input, with bit 0 additionally ORed with the software level.
- R3: Reading index 0 returns the raw levels ANDed with the normal-request mask; reading index 8 returns the raw levels ANDed with the fast-request mask.
- R4: Writing index 2 ORs the written value into the normal-request mask; reading index 2 returns that mask.
- R5: Writing index 3 clears every normal-request mask bit that is 1 in the written value and leaves the others unchanged.
- R6: Index 10 is the set/read register of the fast-request mask and index 11 is its clear register, with the same bit semantics as indices 2 and 3.
- R7: Writing a 1 in bit 0 of index 4 sets the software level, and writing a 1 in bit 0 of index 5 clears it; all other written bits, and a 0 in bit 0, leave it unchanged; reading index 4 returns raw bit 0 in bit 0 with all other bits zero.
- R8: The normal request output equals, one clock later, the OR of all bits of raw levels ANDed with the normal-request mask.
- R9: The fast request output equals, one clock later, the OR of all bits of raw levels ANDed with the fast-request mask.
- R10: Reads of the write-only indices 3, 5 and 11 and of every unassigned index return zero.
- R11: Writes to the read-only indices 0, 1, 8 and 9 and to every unassigned index change neither mask nor the software level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt source inputs |
| wr_en | input | 1 | Register write strobe for the current index |
| addr | input | ADDR_W | Word index of the register accessed |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for the register at addr |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |

## Verification
On every cycle the assertions check that each request line tracks the masked OR of the previous cycle. They also check that set and clear writes land in the correct mask, that a set write raises the software level, and that a write to a read-only index changes no state. The bench scenarios are needed for the behaviour that can only be seen at the ports: the read-back value of every index, the zero reads of write-only and unused indices, and the exact one-cycle delay between a mask write and the request line. They are also needed to show that the upper write bits have no effect on the software level.

// File: rtl/intc_pkg.sv
// Shared register index map for the dual-output interrupt controller.
// Assumes word indexing: the bus presents an index, not a byte offset.
package intc_pkg;
    localparam int IDX_IRQ_MSKD   = 0;
    localparam int IDX_IRQ_RAW    = 1;
    localparam int IDX_IRQ_EN_SET = 2;
    localparam int IDX_IRQ_EN_CLR = 3;
    localparam int IDX_SOFT_SET   = 4;
    localparam int IDX_SOFT_CLR   = 5;
    localparam int IDX_FIQ_MSKD   = 8;
    localparam int IDX_FIQ_RAW    = 9;
    localparam int IDX_FIQ_EN_SET = 10;
    localparam int IDX_FIQ_EN_CLR = 11;
    localparam int NUM_PATHS      = 2;
    localparam int MIN_ADDR_W     = 4;
endpackage

// File: rtl/intc_raw_merge.sv
// Holds the software level and merges it onto source 0 of the raw vector.
// Assumes sources are already synchronous to clk; no edge detection.
module intc_raw_merge #(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wbit0,
    input  logic [NUM_SRC-1:0] src_i,
    output logic               soft_lvl,
    output logic [NUM_SRC-1:0] raw_lvl
);
    import intc_pkg::*;

    logic set_hit;
    logic clr_hit;

    // Decode the two software-level strobes; only bit 0 of the data acts.
    always_comb begin
        set_hit = wr_en && (addr == ADDR_W'(IDX_SOFT_SET)) && wbit0;
        clr_hit = wr_en && (addr == ADDR_W'(IDX_SOFT_CLR)) && wbit0;
    end

    // Software level register, set/clear by its own indices.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_lvl <= 1'b0;
        end else if (set_hit) begin
            soft_lvl <= 1'b1;
        end else if (clr_hit) begin
            soft_lvl <= 1'b0;
        end
    end

    // Raw vector: live inputs, with the software level ORed onto bit 0.
    always_comb begin
        raw_lvl    = src_i;
        raw_lvl[0] = src_i[0] | soft_lvl;
    end
endmodule

// File: rtl/intc_mask_path.sv
// One masked output path: an enable mask changed by set/clear writes and a
// registered request line that is the OR of the raw levels under that mask.
// Assumes a single write per cycle, so a set and a clear never coincide.
module intc_mask_path #(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 4,
    parameter int SET_IDX = 2,
    parameter int CLR_IDX = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_SRC-1:0] wdata,
    input  logic [NUM_SRC-1:0] raw_lvl,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] masked,
    output logic               line_q
);
    logic set_hit;
    logic clr_hit;

    // Decode this path's set and clear indices.
    always_comb begin
        set_hit = wr_en && (addr == ADDR_W'(SET_IDX));
        clr_hit = wr_en && (addr == ADDR_W'(CLR_IDX));
    end

    // Enable mask: OR in on set, AND out on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (set_hit) begin
            en_q <= en_q | wdata;
        end else if (clr_hit) begin
            en_q <= en_q & ~wdata;
        end
    end

    // Masked levels, also used for the status read.
    assign masked = raw_lvl & en_q;

    // Registered request line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b0;
        end else begin
            line_q <= |masked;
        end
    end
endmodule

// File: rtl/intc_read_mux.sv
// Combinational read multiplexer over the index map; zero for write-only
// and unassigned indices. Assumes NUM_SRC <= DATA_W.
module intc_read_mux #(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_SRC-1:0] raw_lvl,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic [NUM_SRC-1:0] fiq_en,
    input  logic [NUM_SRC-1:0] irq_masked,
    input  logic [NUM_SRC-1:0] fiq_masked,
    output logic [DATA_W-1:0]  rdata
);
    import intc_pkg::*;

    // Widen a source-wide vector to the bus width with zero fill.
    function automatic logic [DATA_W-1:0] zext(input logic [NUM_SRC-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[NUM_SRC-1:0] = v;
        return r;
    endfunction

    // Select the register addressed; default returns zero.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(IDX_IRQ_MSKD):   rdata = zext(irq_masked);
            ADDR_W'(IDX_IRQ_RAW):    rdata = zext(raw_lvl);
            ADDR_W'(IDX_IRQ_EN_SET): rdata = zext(irq_en);
            ADDR_W'(IDX_SOFT_SET):   rdata[0] = raw_lvl[0];
            ADDR_W'(IDX_FIQ_MSKD):   rdata = zext(fiq_masked);
            ADDR_W'(IDX_FIQ_RAW):    rdata = zext(raw_lvl);
            ADDR_W'(IDX_FIQ_EN_SET): rdata = zext(fiq_en);
            default:                 rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_fiq_ctrl.sv
// Top: 32-source level interrupt controller with two independently masked
// request outputs sharing one raw level vector. Assumes synchronous sources.
module irq_fiq_ctrl #(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq_o,
    output logic               fiq_o
);
    import intc_pkg::*;

    localparam int NP = NUM_PATHS;

    logic [NUM_SRC-1:0]         raw_lvl;
    logic                       soft_lvl;
    logic [NP-1:0][NUM_SRC-1:0] en_vec;
    logic [NP-1:0][NUM_SRC-1:0] msk_vec;
    logic [NP-1:0]              line_vec;
    logic [NUM_SRC-1:0]         irq_en;
    logic [NUM_SRC-1:0]         fiq_en;

    intc_raw_merge #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_raw (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wbit0    (wdata[0]),
        .src_i    (src_i),
        .soft_lvl (soft_lvl),
        .raw_lvl  (raw_lvl)
    );

    // Path 0 is the normal request, path 1 the fast request.
    for (genvar p = 0; p < NP; p++) begin : g_path
        localparam int SI = (p == 0) ? IDX_IRQ_EN_SET : IDX_FIQ_EN_SET;
        localparam int CI = (p == 0) ? IDX_IRQ_EN_CLR : IDX_FIQ_EN_CLR;
        intc_mask_path #(
            .NUM_SRC (NUM_SRC),
            .ADDR_W  (ADDR_W),
            .SET_IDX (SI),
            .CLR_IDX (CI)
        ) u_path (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .addr    (addr),
            .wdata   (wdata[NUM_SRC-1:0]),
            .raw_lvl (raw_lvl),
            .en_q    (en_vec[p]),
            .masked  (msk_vec[p]),
            .line_q  (line_vec[p])
        );
    end

    // Name the per-path signals for the read mux and the checker.
    always_comb begin
        irq_en = en_vec[0];
        fiq_en = en_vec[1];
        irq_o  = line_vec[0];
        fiq_o  = line_vec[1];
    end

    intc_read_mux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .addr       (addr),
        .raw_lvl    (raw_lvl),
        .irq_en     (irq_en),
        .fiq_en     (fiq_en),
        .irq_masked (msk_vec[0]),
        .fiq_masked (msk_vec[1]),
        .rdata      (rdata)
    );
endmodule

// File: rtl/intc_chk.sv
// Checker for irq_fiq_ctrl, attached by bind; observes ports and the
// internal mask and software-level state.
module intc_chk #(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  wdata,
    input logic               irq_o,
    input logic               fiq_o,
    input logic [NUM_SRC-1:0] raw_lvl,
    input logic [NUM_SRC-1:0] irq_en,
    input logic [NUM_SRC-1:0] fiq_en,
    input logic               soft_lvl
);
    import intc_pkg::*;

    logic [NUM_SRC-1:0] wv;
    logic               ro_hit;
    assign wv = wdata[NUM_SRC-1:0];
    assign ro_hit = wr_en && (addr == ADDR_W'(IDX_IRQ_MSKD) || addr == ADDR_W'(IDX_IRQ_RAW) ||
                              addr == ADDR_W'(IDX_FIQ_MSKD) || addr == ADDR_W'(IDX_FIQ_RAW));

    // R8
    irq_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> irq_o == $past(|(raw_lvl & irq_en)));
    // R9
    fiq_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> fiq_o == $past(|(raw_lvl & fiq_en)));
    // R4
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(IDX_IRQ_EN_SET)) |=> ((irq_en & $past(wv)) == $past(wv)));
    // R5
    irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(IDX_IRQ_EN_CLR)) |=> ((irq_en & $past(wv)) == '0));
    // R6
    fiq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(IDX_FIQ_EN_SET)) |=> ((fiq_en & $past(wv)) == $past(wv)));
    // R6
    fiq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(IDX_FIQ_EN_CLR)) |=> ((fiq_en & $past(wv)) == '0));
    // R7
    soft_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(IDX_SOFT_SET) && wdata[0]) |=> soft_lvl);
    // R11
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ro_hit |=> ($stable(irq_en) && $stable(fiq_en) && $stable(soft_lvl)));
endmodule

bind irq_fiq_ctrl intc_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .irq_o    (irq_o),
    .fiq_o    (fiq_o),
    .raw_lvl  (raw_lvl),
    .irq_en   (irq_en),
    .fiq_en   (fiq_en),
    .soft_lvl (soft_lvl)
);

// File: tb/tb_irq_fiq_ctrl.sv
module tb_irq_fiq_ctrl;
    localparam int NS = 32;
    localparam int DW = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_i = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq_o;
    logic          fiq_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_irq = '0;
    logic [31:0] m_fiq = '0;
    logic        m_soft = 1'b0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    irq_fiq_ctrl #(.NUM_SRC(NS), .DATA_W(DW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    function automatic logic [31:0] m_raw();
        return src_i | {31'b0, m_soft};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(idx); wdata = v;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input int idx, output logic [31:0] v);
        @(negedge clk);
        addr = AW'(idx);
        #1 v = rdata;
    endtask

    task automatic check_lines(input string req);
        check({req, " irq"}, {31'b0, irq_o}, {31'b0, |(m_raw() & m_irq)});
        check({req, " fiq"}, {31'b0, fiq_o}, {31'b0, |(m_raw() & m_fiq)});
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 outputs", {30'b0, irq_o, fiq_o}, 32'h0);
        rd(2, rv);  check("R1 irq mask", rv, 32'h0);
        rd(10, rv); check("R1 fiq mask", rv, 32'h0);
        rd(4, rv);  check("R1 soft", rv, 32'h0);

        // R2: raw level sweep, walking one and walking zero
        for (int i = 0; i < NS; i++) begin
            src_i = 32'h1 << i;
            rd(1, rv); check("R2 raw idx1", rv, src_i);
            src_i = ~(32'h1 << i);
            rd(9, rv); check("R2 raw idx9", rv, src_i);
        end
        src_i = '0;

        // R4: walking set into normal mask
        for (int i = 0; i < NS; i++) begin
            wr(2, 32'h1 << i); m_irq |= 32'h1 << i;
            rd(2, rv); check("R4 irq set", rv, m_irq);
        end
        // R5: clear every even bit one at a time
        for (int i = 0; i < NS; i += 2) begin
            wr(3, 32'h1 << i); m_irq &= ~(32'h1 << i);
            rd(2, rv); check("R5 irq clr", rv, m_irq);
        end

        // R6: fast mask set/clear
        wr(10, 32'hA5A5_5A5A); m_fiq |= 32'hA5A5_5A5A;
        rd(10, rv); check("R6 fiq set", rv, m_fiq);
        wr(10, 32'h0000_0101); m_fiq |= 32'h0000_0101;
        rd(10, rv); check("R6 fiq set accumulate", rv, m_fiq);
        wr(11, 32'h0000_FFFF); m_fiq &= ~32'h0000_FFFF;
        rd(10, rv); check("R6 fiq clr", rv, m_fiq);

        // Known masks for the output sweep
        wr(3, 32'hFFFF_FFFF); m_irq = '0;
        wr(2, 32'h0F0F_00F1); m_irq = 32'h0F0F_00F1;
        wr(11, 32'hFFFF_FFFF); m_fiq = '0;
        wr(10, 32'hF000_0F02); m_fiq = 32'hF000_0F02;

        // R3 R8 R9: every source alone, lines and masked status
        for (int i = 0; i < NS; i++) begin
            src_i = 32'h1 << i;
            @(negedge clk);
            check_lines("R8 R9 sweep");
            rd(0, rv); check("R3 irq masked", rv, m_raw() & m_irq);
            rd(8, rv); check("R3 fiq masked", rv, m_raw() & m_fiq);
        end
        src_i = 32'hFFFF_FFFF;
        rd(0, rv); check("R3 irq masked all", rv, m_irq);
        rd(8, rv); check("R3 fiq masked all", rv, m_fiq);

        // R8: one-cycle latency from enable write to request line
        src_i = 32'h0000_0008;
        @(negedge clk);
        check_lines("R8 idle");
        wr(2, 32'h0000_0008);
        check("R8 before latency", {31'b0, irq_o}, 32'h0);
        m_irq |= 32'h8;
        @(negedge clk);
        check("R8 after latency", {31'b0, irq_o}, 32'h1);
        wr(3, 32'h0000_0008); m_irq &= ~32'h8;
        @(negedge clk);
        check_lines("R8 disabled");
        // R9: latency on the fast line
        wr(10, 32'h0000_0008);
        check("R9 before latency", {31'b0, fiq_o}, 32'h0);
        m_fiq |= 32'h8;
        @(negedge clk);
        check("R9 after latency", {31'b0, fiq_o}, 32'h1);
        wr(11, 32'h0000_0008); m_fiq &= ~32'h8;

        // R7: software level on source 0
        src_i = '0;
        wr(4, 32'hFFFF_FFFE);
        rd(4, rv); check("R7 set upper bits ignored", rv, 32'h0);
        wr(4, 32'h1); m_soft = 1'b1;
        rd(4, rv); check("R7 soft set", rv, 32'h1);
        rd(1, rv); check("R7 soft raw", rv, 32'h1);
        check_lines("R7 soft line");
        wr(5, 32'hFFFF_FFFE);
        rd(4, rv); check("R7 clr upper bits ignored", rv, 32'h1);
        wr(5, 32'h1); m_soft = 1'b0;
        rd(4, rv); check("R7 soft clr", rv, 32'h0);
        check_lines("R7 soft cleared line");
        src_i = 32'h1;
        rd(4, rv); check("R7 hw bit0 read", rv, 32'h1);

        // R10: all non-readable indices read zero with busy state
        src_i = 32'h1234_5679;
        wr(4, 32'h1); m_soft = 1'b1;
        for (int idx = 0; idx < 16; idx++) begin
            if (!(idx inside {0, 1, 2, 4, 8, 9, 10})) begin
                rd(idx, rv); check("R10 zero read", rv, 32'h0);
            end
        end

        // R11: writes to read-only and unused indices change nothing
        for (int idx = 0; idx < 16; idx++) begin
            if (idx inside {0, 1, 6, 7, 8, 9, 12, 13, 14, 15}) begin
                wr(idx, 32'hFFFF_FFFF);
                rd(2, rv);  check("R11 irq mask kept", rv, m_irq);
                rd(10, rv); check("R11 fiq mask kept", rv, m_fiq);
            end
        end
        src_i = '0;
        rd(4, rv); check("R11 soft kept", rv, 32'h1);
        check_lines("R11 lines");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule